// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block turns one external-data-memory request into a timed cycle of address, read strobe and write strobe on a memory port. All widths are counted in processor clock cycles. A 3-bit stretch setting (0 to 7), held in a small configuration register, makes both the address phase and the strobes longer. Slow or shared memories can then be reached without changing the requester.

The requester presents a direction, an address and, for writes, the data, and raises `req_valid`. The block takes the request when it is idle. From the next cycle it drives the address valid for the whole address phase, and the strobe sits inside that phase. After the phase ends it gives a one-cycle `done` pulse. For reads, the data sampled in the last strobe cycle is shown on `rdata`. The stretch is copied when a request is taken, so a new setting written during an access applies only to later accesses.

A request is taken in any cycle where no address phase is running, and this includes the `done` cycle.

Top module: `xms_strobe_seq`

## Requirements
- R1: After reset, `mem_addr_vld`, `mem_rd`, `mem_wr` and `done` are low and the stretch setting S equals 1.
- R2: A read taken at a clock edge drives `mem_addr_vld` high for exactly S+1 cycles, starting in the cycle after that edge.
- R3: During a read, `mem_rd` is high in every cycle of the address phase and in no other cycle, and `mem_wr` stays low.
- R4: `rdata` takes the value of `mem_rdata` from the last read-strobe cycle. It is valid while `done` is high and keeps that value until the next read ends; a write does not change it.
- R5: A write drives `mem_addr_vld` high for exactly S+2 cycles, starting in the cycle after the request is taken.
- R6: During a write, `mem_wr` is high for 1 cycle when S is 0 or 1 and for S cycles when S is 2 to 7. It falls in the last cycle of the address phase, so its final high cycle is the second-to-last cycle of the phase. `mem_rd` stays low.
- R7: During the address phase, `mem_addr` equals the address taken with the request, and for writes `mem_wdata` equals the taken data. Neither changes within the phase.
- R8: `done` is high for exactly one cycle, the cycle right after the last address-valid cycle, and is low at all other times.
- R9: A request raised while an address phase is running is ignored. It starts no access and does not change the running address, data or timing.
- R10: A stretch value written with `cfg_we` during an access leaves that access unchanged and sets the timing of every later access.
- R11: `mem_rd` and `mem_wr` are never high together, and neither is high outside the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Writes `cfg_stretch` into the stretch register |
| cfg_stretch | input | STRETCH_W | New stretch setting |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| mem_addr | output | ADDR_W | Memory address |
| mem_addr_vld | output | 1 | Address phase active |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |

## Verification
The bench sweeps every stretch value for both directions and goes after the corner cases most likely to be wrong.

- **S=0 read:** the address phase is one cycle long. A design with an off-by-one phase counter would stretch it or lose `done`.
- **S=0 and S=1 writes:** the write strobe must stay one cycle wide. A design that used S directly would give a zero-width strobe or a strobe that is too wide.
- **Request held into a running phase:** a design that wrongly takes it would change the address in mid-phase or start a second access.
- **Stretch written mid-access:** a design that reads the live register would change the timing of the running access.
- **Reads followed by writes:** these show whether `rdata` wrongly follows the memory outside a read.

// File: rtl/xms_pkg.sv
package xms_pkg;
  typedef enum logic {
    XM_READ  = 1'b0,
    XM_WRITE = 1'b1
  } xm_dir_e;
endpackage

// File: rtl/xms_cfg_reg.sv
// Stretch configuration register with a parameterised reset value.
module xms_cfg_reg #(
  parameter int STRETCH_W = 3,
  parameter int RST_VAL   = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [STRETCH_W-1:0] din,
  output logic [STRETCH_W-1:0] stretch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stretch <= STRETCH_W'(RST_VAL);
    end else if (we) begin
      stretch <= din;
    end
  end
endmodule

// File: rtl/xms_timing.sv
// Derives the phase length and the strobe window (phase indices) from
// the direction and the stretch value. Index 0 is the first address cycle.
module xms_timing
  import xms_pkg::*;
#(
  parameter int STRETCH_W = 3,
  parameter int CNT_W     = STRETCH_W + 1
) (
  input  xm_dir_e              dir,
  input  logic [STRETCH_W-1:0] stretch,
  output logic [CNT_W-1:0]     len,
  output logic [CNT_W-1:0]     str_first,
  output logic [CNT_W-1:0]     str_last
);
  logic [CNT_W-1:0] s_ext;

  always_comb begin
    s_ext    = CNT_W'(stretch);
    str_last = s_ext;
    if (dir == XM_WRITE) begin
      len = s_ext + CNT_W'(2);
      // Write strobe ends one cycle before the phase; one cycle wide for S<2.
      str_first = (s_ext == '0) ? '0 : CNT_W'(1);
    end else begin
      len       = s_ext + CNT_W'(1);
      str_first = '0;
    end
  end
endmodule

// File: rtl/xms_core.sv
// Phase counter and registered memory-side outputs.
module xms_core
  import xms_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  xm_dir_e           req_dir,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  t_len,
  input  logic [CNT_W-1:0]  t_first,
  input  logic [CNT_W-1:0]  t_last,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_vld,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic             busy;
  xm_dir_e          dir_q;
  logic [CNT_W-1:0] ph;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] first_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] ph_nxt;
  logic             ph_end;
  logic             win_nxt;
  logic             first_on;

  always_comb begin
    ph_nxt   = ph + CNT_W'(1);
    ph_end   = (ph == (len_q - CNT_W'(1)));
    win_nxt  = (ph_nxt >= first_q) && (ph_nxt <= last_q);
    first_on = (t_first == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      dir_q        <= XM_READ;
      ph           <= '0;
      len_q        <= CNT_W'(1);
      first_q      <= '0;
      last_q       <= '0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_addr_vld <= 1'b0;
      mem_rd       <= 1'b0;
      mem_wr       <= 1'b0;
      done         <= 1'b0;
      rdata        <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy         <= 1'b1;
          dir_q        <= req_dir;
          ph           <= '0;
          len_q        <= t_len;
          first_q      <= t_first;
          last_q       <= t_last;
          mem_addr     <= req_addr;
          mem_wdata    <= req_wdata;
          mem_addr_vld <= 1'b1;
          mem_rd       <= (req_dir == XM_READ) && first_on;
          mem_wr       <= (req_dir == XM_WRITE) && first_on;
        end
      end else begin
        if ((dir_q == XM_READ) && (ph == last_q)) begin
          rdata <= mem_rdata;
        end
        if (ph_end) begin
          busy         <= 1'b0;
          mem_addr_vld <= 1'b0;
          mem_rd       <= 1'b0;
          mem_wr       <= 1'b0;
          done         <= 1'b1;
        end else begin
          ph     <= ph_nxt;
          mem_rd <= (dir_q == XM_READ) && win_nxt;
          mem_wr <= (dir_q == XM_WRITE) && win_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/xms_strobe_seq.sv
module xms_strobe_seq
  import xms_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int STRETCH_W   = 3,
  parameter int STRETCH_RST = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [STRETCH_W-1:0] cfg_stretch,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_addr_vld,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 done,
  output logic [DATA_W-1:0]    rdata
);
  localparam int CNT_W = STRETCH_W + 1;

  xm_dir_e              req_dir;
  logic [STRETCH_W-1:0] stretch;
  logic [CNT_W-1:0]     t_len;
  logic [CNT_W-1:0]     t_first;
  logic [CNT_W-1:0]     t_last;

  assign req_dir = req_write ? XM_WRITE : XM_READ;

  xms_cfg_reg #(.STRETCH_W(STRETCH_W), .RST_VAL(STRETCH_RST)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .din(cfg_stretch), .stretch(stretch)
  );

  xms_timing #(.STRETCH_W(STRETCH_W), .CNT_W(CNT_W)) u_tim (
    .dir(req_dir), .stretch(stretch),
    .len(t_len), .str_first(t_first), .str_last(t_last)
  );

  xms_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_dir(req_dir),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .t_len(t_len), .t_first(t_first), .t_last(t_last),
    .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .rdata(rdata)
  );
endmodule

// File: rtl/xms_checker.sv
module xms_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_addr_vld,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          done
);
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r11_strobe_in_phase: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> mem_addr_vld);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_phase: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_addr_vld) |-> done);

  a_r8_done_not_in_phase: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_addr_vld);

  a_r7_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_addr_vld && $past(mem_addr_vld)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  a_r3_rd_to_end: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_rd) |-> !mem_addr_vld);

  a_r6_wr_ends_early: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr) |-> mem_addr_vld);
endmodule

bind xms_strobe_seq xms_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr_vld(mem_addr_vld), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
);

// File: tb/test_xms_strobe_seq.sv
module test_xms_strobe_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_stretch = 3'd0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_addr_vld;
  logic          mem_rd;
  logic          mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          done;
  logic [DW-1:0] rdata;

  logic [DW-1:0] mem    [0:255];
  logic [DW-1:0] shadow [0:255];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int cur_s = 1;
  logic [DW-1:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xms_strobe_seq #(.ADDR_W(AW), .DATA_W(DW)) i_xms_strobe_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .rdata(rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // Expected phase length and strobe window from the requirements
  function automatic int exp_len(input bit wr, input int s);
    return wr ? s + 2 : s + 1;
  endfunction
  function automatic int exp_width(input bit wr, input int s);
    if (!wr) return s + 1;
    return (s < 2) ? 1 : s;
  endfunction
  function automatic int exp_first(input bit wr, input int s);
    return wr ? exp_len(1, s) - 1 - exp_width(1, s) : 0;
  endfunction

  task automatic set_stretch(input int s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_stretch = 3'(s);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_s = s;
  endtask

  task automatic run_acc(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit disturb, input bit restretch, input int new_s);
    int n_vld, n_str, f, l, k, bad_addr, bad_other;
    string tl, ts;
    n_vld = 0; n_str = 0; f = -1; l = -1; k = 0; bad_addr = 0; bad_other = 0;
    tl = wr ? "R5" : "R2";
    ts = wr ? "R6" : "R3";
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (disturb) begin
      req_write = !wr; req_addr = ~a; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    if (restretch) begin
      cfg_we = 1'b1; cfg_stretch = 3'(new_s);
    end
    while (mem_addr_vld && k < 20) begin
      n_vld++;
      if (wr ? mem_wr : mem_rd) begin
        n_str++;
        if (f < 0) f = k;
        l = k;
      end
      if (mem_addr !== a || (wr && mem_wdata !== d)) bad_addr++;
      if ((wr ? mem_rd : mem_wr) || done) bad_other++;
      @(negedge clk);
      k++;
      req_valid = 1'b0; cfg_we = 1'b0;
    end
    chk(n_vld == exp_len(wr, cur_s), restretch ? "R10" : tl, n_vld, exp_len(wr, cur_s));
    chk(n_str == exp_width(wr, cur_s), ts, n_str, exp_width(wr, cur_s));
    chk(f == exp_first(wr, cur_s), ts, f, exp_first(wr, cur_s));
    chk(l == f + n_str - 1, ts, l, f + n_str - 1);
    chk(bad_addr == 0, disturb ? "R9" : "R7", bad_addr, 0);
    chk(bad_other == 0, "R11", bad_other, 0);
    chk(done == 1'b1, "R8", done, 1);
    if (!wr) begin
      chk(rdata == shadow[a], "R4", rdata, shadow[a]);
      last_rd = shadow[a];
    end else begin
      chk(rdata == last_rd, "R4", rdata, last_rd);
      shadow[a] = d;
    end
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
    chk(mem_addr_vld == 1'b0, "R9", mem_addr_vld, 0);
    if (restretch) cur_s = new_s;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(mem_addr_vld == 0 && mem_rd == 0 && mem_wr == 0 && done == 0, "R1",
        {mem_addr_vld, mem_rd, mem_wr, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_addr_vld == 0 && done == 0, "R1", {mem_addr_vld, done}, 0);
    // R1: default stretch 1 -> read phase of 2, write phase of 3
    run_acc(1'b0, 8'h10, 8'h00, 1'b0, 1'b0, 0);
    run_acc(1'b1, 8'h11, 8'hA5, 1'b0, 1'b0, 0);
    // Sweep every stretch value in both directions
    for (int s = 0; s < 8; s++) begin
      set_stretch(s);
      run_acc(1'b1, 8'(s + 32), 8'(s * 17 + 1), 1'b0, 1'b0, 0);
      run_acc(1'b0, 8'(s + 32), 8'h00, 1'b0, 1'b0, 0);
      run_acc(1'b0, 8'(s + 64), 8'h00, 1'b1, 1'b0, 0);
    end
    // R10: stretch change during S=0 and S=7 accesses
    set_stretch(0);
    run_acc(1'b0, 8'h05, 8'h00, 1'b0, 1'b1, 7);
    run_acc(1'b1, 8'h06, 8'h3C, 1'b1, 1'b1, 2);
    run_acc(1'b0, 8'h06, 8'h00, 1'b0, 1'b0, 0);
    // Random mix
    for (int i = 0; i < 60; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) set_stretch(int'($urandom % 8));
      run_acc(1'($urandom), 8'($urandom), 8'($urandom), ($urandom % 4) == 0,
              ($urandom % 6) == 0, int'($urandom % 8));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule